// File: doc/BRIEF.md
# Postfix Stack Calculator

This block evaluates arithmetic expressions that arrive in postfix order. A client issues a stream of commands, each an opcode and a data-memory address, over a valid/ready handshake. Push copies a word from a small internal data memory onto an operand stack. Pop moves the top of the stack back into a data-memory word. The four binary operations (add, subtract, multiply, divide) combine the two topmost entries into one.

A binary operation treats the top entry as its left operand and the entry beneath it as its right operand. The result replaces the lower entry and the stack shrinks by one. Divide is unsigned and runs over several cycles, with `busy` raised for the whole run. Faults raise a sticky error flag that only reset clears. These faults are a push onto a full stack, a pop or binary operation with too few entries, and a divide by zero.

A side port on the data memory lets a host load operands before a run and read results afterwards, while no command is in flight.

Top module: `postfix_stack_unit`

## Requirements
- R1: After reset the stack is empty, `busy` and `err` are 0, `cmdReady` is 1 and every data-memory word reads 0.
- R2: Push (opcode 0) raises the stack depth by one and places a copy of data-memory word `cmdAddr` on top.
- R3: Pop (opcode 1) writes the top entry into data-memory word `cmdAddr` and removes it, so successive pops return entries in reverse push order.
- R4: Add (opcode 2) and multiply (opcode 4) replace the two top entries with their sum, or with the low 16 bits of their product.
- R5: Subtract (opcode 3) yields top minus the entry below it, modulo 2^16.
- R6: Divide (opcode 5) yields the unsigned quotient of top divided by the entry below it. From the accepting edge, `busy` is 1 and `cmdReady` is 0 for exactly 16 clock cycles. `cmdReady` always equals the inverse of `busy`.
- R7: A divide whose divisor (the entry below top) is zero yields 0xFFFF and sets `err`.
- R8: A push while the stack holds 16 entries is rejected and sets `err`. The stack contents and depth are unchanged.
- R9: A pop on an empty stack, or a binary operation with fewer than two entries, is rejected and sets `err`. The stack and data memory are unchanged.
- R10: `err` stays 1 once set, through later legal commands, until reset.
- R11: `memRdata` always shows data-memory word `memAddr`. A side write with `memWe` takes effect only when `busy` is 0 and `cmdValid` is 0.
- R12: Opcodes 6 and 7 are accepted and leave the stack, the data memory and `err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | A command is presented |
| cmdReady | output | 1 | Unit can take a command this cycle |
| cmdOp | input | 3 | Opcode: 0 push, 1 pop, 2 add, 3 sub, 4 mul, 5 div, 6/7 no effect |
| cmdAddr | input | 4 | Data-memory word used by push or pop |
| busy | output | 1 | Divide in progress |
| err | output | 1 | Sticky fault flag |
| memWe | input | 1 | Side-port write enable |
| memAddr | input | 4 | Side-port word address |
| memWdata | input | 16 | Side-port write data |
| memRdata | output | 16 | Side-port read data |

## Verification
A wrong stack pointer or a corrupted stack slot stays hidden until a later pop carries the bad value into data memory. The side port exposes it at the latest at that pop. The same fault can also show up first as a spurious or missing `err` on the next push, pop or operation at a depth boundary. A divider whose count is off by one, or whose sequencing is wrong, shows at once in the cycle-by-cycle `busy` comparison. A swapped operand order or a wrong step shows only in the quotient popped afterwards, so the tests use asymmetric operand pairs for subtract and divide.

// File: rtl/stack_unit_pkg.sv
package stack_unit_pkg;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5,
    OP_NOP6 = 3'd6,
    OP_NOP7 = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_MUL = 2'd2
  } aluSel_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic    pushEn;
    logic    popEn;
    logic    aluEn;
    aluSel_e aluSel;
    logic    divLoad;
    logic    divStep;
    logic    divDone;
    logic    sideWe;
  } ctrlStrobe_t;

endpackage

// File: rtl/stk_divider.sv
module stk_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quoNext
);

  logic [W-1:0] remR, quoR, dvsR;
  logic [W:0]   shifted, diff;
  logic         fits;
  logic [W-1:0] remNext;

  // one restoring step per cycle, quotient bits enter from the right
  always_comb begin
    shifted = {remR, quoR[W-1]};
    diff    = shifted - {1'b0, dvsR};
    fits    = ~diff[W];
    remNext = fits ? diff[W-1:0] : shifted[W-1:0];
    quoNext = {quoR[W-2:0], fits};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR <= '0;
      quoR <= '0;
      dvsR <= '0;
    end else if (load) begin
      remR <= '0;
      quoR <= dividend;
      dvsR <= divisor;
    end else if (step) begin
      remR <= remNext;
      quoR <= quoNext;
    end
  end

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stack_unit_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int SPW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdValid,
  input  logic [2:0]     cmdOp,
  input  logic [SPW-1:0] spCount,
  input  logic           divisorZero,
  input  logic           memWe,
  output logic           cmdReady,
  output logic           busy,
  output logic           errFlag,
  output ctrlStrobe_t    strobe
);

  localparam int CNTW = $clog2(W);

  typedef enum logic {S_IDLE, S_DIV} state_e;

  state_e          state;
  logic [CNTW-1:0] stepCnt;
  opcode_e         op;
  logic            accept, legal, errSet;

  assign op       = opcode_e'(cmdOp);
  assign busy     = (state == S_DIV);
  assign cmdReady = (state == S_IDLE);
  assign accept   = cmdValid && cmdReady;

  always_comb begin
    unique case (op)
      OP_PUSH:                        legal = (spCount < SPW'(DEPTH));
      OP_POP:                         legal = (spCount != '0);
      OP_ADD, OP_SUB, OP_MUL, OP_DIV: legal = (spCount >= SPW'(2));
      default:                        legal = 1'b1;
    endcase
  end

  always_comb begin
    strobe         = '0;
    strobe.aluSel  = ALU_ADD;
    strobe.sideWe  = memWe && (state == S_IDLE) && !cmdValid;
    strobe.divStep = (state == S_DIV);
    strobe.divDone = (state == S_DIV) && (stepCnt == CNTW'(W - 1));
    if (accept && legal) begin
      unique case (op)
        OP_PUSH: strobe.pushEn  = 1'b1;
        OP_POP:  strobe.popEn   = 1'b1;
        OP_ADD:  strobe.aluEn   = 1'b1;
        OP_SUB: begin
          strobe.aluEn  = 1'b1;
          strobe.aluSel = ALU_SUB;
        end
        OP_MUL: begin
          strobe.aluEn  = 1'b1;
          strobe.aluSel = ALU_MUL;
        end
        OP_DIV:  strobe.divLoad = 1'b1;
        default: ;
      endcase
    end
  end

  assign errSet = accept && (!legal || (op == OP_DIV && divisorZero));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      errFlag <= 1'b0;
    end else begin
      if (errSet) errFlag <= 1'b1;
      unique case (state)
        S_IDLE: begin
          stepCnt <= '0;
          if (strobe.divLoad) state <= S_DIV;
        end
        S_DIV: begin
          stepCnt <= stepCnt + CNTW'(1);
          if (strobe.divDone) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/stk_datapath.sv
module stk_datapath
  import stack_unit_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int MEMW  = 16,
  parameter int AW    = $clog2(MEMW),
  parameter int SPW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrlStrobe_t    strobe,
  input  logic [AW-1:0]  cmdAddr,
  input  logic [AW-1:0]  memAddr,
  input  logic [W-1:0]   memWdata,
  output logic [W-1:0]   memRdata,
  output logic [SPW-1:0] spCount,
  output logic           divisorZero
);

  localparam int IDXW = $clog2(DEPTH);

  logic [W-1:0]    stk  [DEPTH];
  logic [W-1:0]    dmem [MEMW];
  logic [IDXW-1:0] topIdx, belowIdx, pushIdx;
  logic [W-1:0]    topVal, belowVal, aluRes, divQuo;

  // slot k (1-based) lives at index k-1
  assign topIdx   = IDXW'(spCount - SPW'(1));
  assign belowIdx = IDXW'(spCount - SPW'(2));
  assign pushIdx  = IDXW'(spCount);
  assign topVal   = stk[topIdx];
  assign belowVal = stk[belowIdx];

  assign divisorZero = (belowVal == '0);
  assign memRdata    = dmem[memAddr];

  always_comb begin
    unique case (strobe.aluSel)
      ALU_SUB: aluRes = topVal - belowVal;
      ALU_MUL: aluRes = topVal * belowVal;
      default: aluRes = topVal + belowVal;
    endcase
  end

  stk_divider #(.W(W)) div_i (
    .clk      (clk),
    .rstN     (rstN),
    .load     (strobe.divLoad),
    .step     (strobe.divStep),
    .dividend (topVal),
    .divisor  (belowVal),
    .quoNext  (divQuo)
  );

  always_ff @(posedge clk) begin
    if (strobe.pushEn)       stk[pushIdx]  <= dmem[cmdAddr];
    else if (strobe.aluEn)   stk[belowIdx] <= aluRes;
    else if (strobe.divDone) stk[belowIdx] <= divQuo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spCount <= '0;
    end else if (strobe.pushEn) begin
      spCount <= spCount + SPW'(1);
    end else if (strobe.popEn || strobe.aluEn || strobe.divDone) begin
      spCount <= spCount - SPW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEMW; i++) dmem[i] <= '0;
    end else if (strobe.popEn) begin
      dmem[cmdAddr] <= topVal;
    end else if (strobe.sideWe) begin
      dmem[memAddr] <= memWdata;
    end
  end

endmodule

// File: rtl/postfix_stack_unit.sv
module postfix_stack_unit
  import stack_unit_pkg::*;
#(
  parameter  int W     = 16,
  parameter  int DEPTH = 16,
  parameter  int MEMW  = 16,
  localparam int AW    = $clog2(MEMW)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  output logic          cmdReady,
  input  logic [2:0]    cmdOp,
  input  logic [AW-1:0] cmdAddr,
  output logic          busy,
  output logic          err,
  input  logic          memWe,
  input  logic [AW-1:0] memAddr,
  input  logic [W-1:0]  memWdata,
  output logic [W-1:0]  memRdata
);

  localparam int SPW = $clog2(DEPTH + 1);

  ctrlStrobe_t    strobe;
  logic [SPW-1:0] spCount;
  logic           divisorZero;

  stk_ctrl #(.W(W), .DEPTH(DEPTH), .SPW(SPW)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdOp       (cmdOp),
    .spCount     (spCount),
    .divisorZero (divisorZero),
    .memWe       (memWe),
    .cmdReady    (cmdReady),
    .busy        (busy),
    .errFlag     (err),
    .strobe      (strobe)
  );

  stk_datapath #(.W(W), .DEPTH(DEPTH), .MEMW(MEMW), .AW(AW), .SPW(SPW)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdAddr     (cmdAddr),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .memRdata    (memRdata),
    .spCount     (spCount),
    .divisorZero (divisorZero)
  );

endmodule

// File: rtl/stk_unit_chk.sv
module stk_unit_chk
  import stack_unit_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int SPW   = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rstN,
  input logic           cmdValid,
  input logic           cmdReady,
  input logic [2:0]     cmdOp,
  input logic           busy,
  input logic           err,
  input logic [SPW-1:0] spCount
);

  localparam int CW = $clog2(W) + 2;

  logic [CW-1:0] busyRun;
  logic          acc;

  assign acc = cmdValid && cmdReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + CW'(1);
    else           busyRun <= '0;
  end

  p_ready_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady != busy);

  p_div_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= CW'(W));

  p_div_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == CW'(W));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    err |=> err);

  p_sp_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    spCount <= SPW'(DEPTH));

  p_push_grow_r2: assert property (@(posedge clk) disable iff (!rstN)
    acc && cmdOp == OP_PUSH && spCount < SPW'(DEPTH)
      |=> spCount == $past(spCount) + SPW'(1));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    acc && cmdOp == OP_PUSH && spCount == SPW'(DEPTH)
      |=> err && $stable(spCount));

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    acc && cmdOp == OP_POP && spCount == '0 |=> err && spCount == '0);

endmodule

bind postfix_stack_unit stk_unit_chk #(.W(W), .DEPTH(DEPTH), .SPW(SPW)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .cmdOp    (cmdOp),
  .busy     (busy),
  .err      (err),
  .spCount  (spCount)
);

// File: tb/postfix_stack_unit_tb_top.sv
module postfix_stack_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [2:0]  cmdOp = '0;
  logic [3:0]  cmdAddr = '0;
  logic        busy, err;
  logic        memWe = 1'b0;
  logic [3:0]  memAddr = '0;
  logic [15:0] memWdata = '0;
  logic [15:0] memRdata;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  logic [15:0] stkQ[$];
  logic [15:0] memM[16];
  logic        expBusy = 1'b0;
  logic        expErr = 1'b0;
  logic        running = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  postfix_stack_unit dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .busy(busy), .err(err),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rstN && running) begin
      check("R6 busy", {15'b0, busy}, {15'b0, expBusy});
      check("R6 ready", {15'b0, cmdReady}, {15'b0, !expBusy});
      check("R10 err", {15'b0, err}, {15'b0, expErr});
      check("R11 rdata", memRdata, memM[memAddr]);
    end
  end

  task automatic doReset();
    running = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    stkQ.delete();
    foreach (memM[i]) memM[i] = '0;
    expBusy = 1'b0;
    expErr = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
  endtask

  task automatic sideWrite(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    memWe = 1'b1; memAddr = a; memWdata = d;
    @(posedge clk);
    #1;
    memWe = 1'b0;
    memM[a] = d;
  endtask

  task automatic readMem(logic [3:0] a, logic [15:0] exp, string req);
    @(negedge clk);
    memAddr = a;
    #1;
    check(req, memRdata, exp);
  endtask

  task automatic doCmd(logic [2:0] op, logic [3:0] addr);
    int n;
    logic [15:0] t, b, r;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = addr;
    @(posedge clk);
    #1;
    cmdValid = 1'b0;
    n = stkQ.size();
    case (op)
      3'd0: if (n < 16) stkQ.push_back(memM[addr]); else expErr = 1'b1;
      3'd1: if (n >= 1) memM[addr] = stkQ.pop_back(); else expErr = 1'b1;
      3'd2, 3'd3, 3'd4, 3'd5: begin
        if (n < 2) expErr = 1'b1;
        else begin
          t = stkQ[n-1];
          b = stkQ[n-2];
          case (op)
            3'd2: r = t + b;
            3'd3: r = t - b;
            3'd4: r = t * b;
            default: begin
              if (b == 16'd0) begin r = 16'hFFFF; expErr = 1'b1; end
              else r = t / b;
            end
          endcase
          if (op == 3'd5) begin
            expBusy = 1'b1;
            repeat (16) @(posedge clk);
            #1;
            expBusy = 1'b0;
          end
          void'(stkQ.pop_back());
          void'(stkQ.pop_back());
          stkQ.push_back(r);
        end
      end
      default: ;
    endcase
  endtask

  task automatic preload();
    sideWrite(4'd0, 16'd100);
    sideWrite(4'd1, 16'd7);
    sideWrite(4'd2, 16'hFFF0);
    sideWrite(4'd3, 16'd3);
    sideWrite(4'd4, 16'd0);
    sideWrite(4'd5, 16'h1234);
    sideWrite(4'd6, 16'h0100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 busy", {15'b0, busy}, 16'd0);
    check("R1 ready", {15'b0, cmdReady}, 16'd1);
    check("R1 err", {15'b0, err}, 16'd0);
    readMem(4'd9, 16'd0, "R1 mem");

    preload();
    readMem(4'd5, 16'h1234, "R11 readback");

    // R4 add, R2 push copies
    doCmd(3'd0, 4'd0); doCmd(3'd0, 4'd1); doCmd(3'd2, 4'd0);
    doCmd(3'd1, 4'd8);
    readMem(4'd8, 16'd107, "R4 add");

    // R5 subtract order both ways
    doCmd(3'd0, 4'd1); doCmd(3'd0, 4'd0); doCmd(3'd3, 4'd0);
    doCmd(3'd1, 4'd9);
    readMem(4'd9, 16'd93, "R5 sub top-below");
    doCmd(3'd0, 4'd0); doCmd(3'd0, 4'd1); doCmd(3'd3, 4'd0);
    doCmd(3'd1, 4'd10);
    readMem(4'd10, 16'hFFA3, "R5 sub wrap");

    // R4 multiply low half
    doCmd(3'd0, 4'd2); doCmd(3'd0, 4'd6); doCmd(3'd4, 4'd0);
    doCmd(3'd1, 4'd11);
    readMem(4'd11, 16'hF000, "R4 mul");

    // R3 LIFO order
    doCmd(3'd0, 4'd3); doCmd(3'd0, 4'd5);
    doCmd(3'd1, 4'd12); doCmd(3'd1, 4'd13);
    readMem(4'd12, 16'h1234, "R3 first pop");
    readMem(4'd13, 16'd3, "R3 second pop");

    // R6 divide
    doCmd(3'd0, 4'd1); doCmd(3'd0, 4'd0); doCmd(3'd5, 4'd0);
    doCmd(3'd1, 4'd14);
    readMem(4'd14, 16'd14, "R6 div");
    check("R6 no err", {15'b0, err}, 16'd0);

    // R12 reserved opcode, R11 side write blocked by presented command
    doCmd(3'd0, 4'd3);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd6; cmdAddr = 4'd15;
    memWe = 1'b1; memAddr = 4'd7; memWdata = 16'hBEEF;
    @(posedge clk);
    #1;
    cmdValid = 1'b0; memWe = 1'b0;
    readMem(4'd7, 16'd0, "R11 side write blocked");
    readMem(4'd15, 16'd0, "R12 nop mem");
    check("R12 nop err", {15'b0, err}, 16'd0);
    doCmd(3'd1, 4'd15);
    readMem(4'd15, 16'd3, "R12 stack intact");

    // R9 underflow pop, R10 sticky
    doCmd(3'd1, 4'd15);
    check("R9 pop empty err", {15'b0, err}, 16'd1);
    readMem(4'd15, 16'd3, "R9 mem unchanged");
    doCmd(3'd0, 4'd0);
    check("R10 sticky", {15'b0, err}, 16'd1);
    doCmd(3'd2, 4'd0);
    doCmd(3'd1, 4'd13);
    readMem(4'd13, 16'd100, "R9 single-entry op rejected");

    // R10 cleared only by reset; R8 overflow
    doReset();
    check("R10 reset clears", {15'b0, err}, 16'd0);
    preload();
    for (int i = 0; i < 16; i++) doCmd(3'd0, 4'd0);
    check("R8 full no err", {15'b0, err}, 16'd0);
    doCmd(3'd0, 4'd5);
    check("R8 overflow err", {15'b0, err}, 16'd1);
    doCmd(3'd1, 4'd12);
    readMem(4'd12, 16'd100, "R8 top unchanged");
    for (int i = 0; i < 15; i++) doCmd(3'd1, 4'd13);
    readMem(4'd13, 16'd100, "R8 bottom entry");

    // R7 divide by zero
    doReset();
    preload();
    doCmd(3'd0, 4'd4); doCmd(3'd0, 4'd0); doCmd(3'd5, 4'd0);
    check("R7 err", {15'b0, err}, 16'd1);
    doCmd(3'd1, 4'd9);
    readMem(4'd9, 16'hFFFF, "R7 quotient");

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule